// File: doc/BRIEF.md
# Steerable PTP Time Counter

This block keeps a precision-time-protocol time of day inside one 125 MHz clock domain. On every clock edge it adds a programmable period to a time value that has a 48-bit seconds field, a nanoseconds field that stays below one billion, and a 32-bit fraction of a nanosecond. The top 8 fraction bits are the output resolution. Because the period carries 32 fractional bits, a software servo can trim the counter's rate in steps of 2^-32 ns per cycle.

The host drives three steering strobes:
- **Load** sets seconds, nanoseconds and the 8 visible fraction bits all at once.
- **Adjust** adds a signed nanosecond offset to the running time in a single step.
- **Period write** replaces the per-cycle increment.

A steering action never swallows that cycle's increment. A one-cycle tick marks every rollover of nanoseconds into seconds. Downstream logic reads the time outputs directly.

Top module: `ptp_time_counter`

## Requirements
- R1: While rst_ni is low, sec_o, ns_o, frac_o and pps_tick_o are all zero. The period is 8 ns with a zero fraction. The first edge after release shows 8 ns.
- R2: When no steering strobe is high, every edge adds the period (integer ns plus 32-bit fraction) to the internal time. A carry out of the 32-bit fraction adds one nanosecond. frac_o is bits [31:24] of the internal fraction.
- R3: ns_o never reaches 1,000,000,000. A sum at or above that value is reduced by 1,000,000,000 and increments sec_o. sec_o wraps modulo 2^48.
- R4: pps_tick_o is high for the single cycle that follows an edge at which nanoseconds overflowed into seconds, whatever the source of the overflow. At all other times it is low.
- R5: With load_i high at an edge, the new time is the loaded value plus the period in effect. The loaded fraction is ld_frac_i placed in bits [31:24], with bits [23:0] zero.
- R6: With adjust_i high (and load_i low) at an edge, the new time is the old time plus the period plus the signed offset adj_ns_i. The offset must satisfy |adj_ns_i| < 1,000,000,000. The period is not changed.
- R7: A result below zero nanoseconds borrows one second: 1,000,000,000 is added to ns and sec_o is decremented modulo 2^48. A borrow does not raise pps_tick_o.
- R8: With period_we_i high at an edge, per_ns_i and per_frac_i become the period. The increment at that same edge still uses the old period. Every later edge uses the new one.
- R9: When load_i and adjust_i are high at the same edge, the load is applied and the offset is ignored.
- R10: A period write in the same edge as a load or an adjust applies both actions. The steered result includes the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Absolute time load strobe |
| ld_sec_i | input | SEC_W (48) | Seconds to load |
| ld_ns_i | input | 30 | Nanoseconds to load, below 1e9 |
| ld_frac_i | input | OUT_FRAC_W (8) | Fractional nanoseconds to load |
| adjust_i | input | 1 | One-shot offset strobe |
| adj_ns_i | input | ADJ_W (32) | Signed offset in ns, two's complement |
| period_we_i | input | 1 | Period write strobe |
| per_ns_i | input | PER_NS_W (8) | New period, integer ns |
| per_frac_i | input | FRAC_W (32) | New period, fraction in units of 2^-32 ns |
| sec_o | output | SEC_W (48) | Current seconds |
| ns_o | output | 30 | Current nanoseconds |
| frac_o | output | OUT_FRAC_W (8) | Current fraction in units of 2^-8 ns |
| pps_tick_o | output | 1 | One-cycle pulse after each seconds carry |

## Verification
Steering and the free-running increment share every edge. The sharpest overlaps are:
- a load or adjust landing on the very edge where the fraction carries or nanoseconds roll over;
- a period write issued together with an adjust.

The bench provokes both by:
- loading times a few nanoseconds short of a second, then adjusting across the boundary in both directions;
- writing a new period in the same cycle as a load or adjust.

A behavioural integer model, fed the same strobes, is compared on every cycle. It judges whether the old period was used once and only once, whether the offset was dropped under a load, and whether the tick followed a carry but not a borrow.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;
  localparam int NS_W = 30;

  typedef enum logic [1:0] {
    STEER_NONE = 2'd0,
    STEER_LOAD = 2'd1,
    STEER_ADJ  = 2'd2
  } steer_e;
endpackage

// File: rtl/ptp_period_reg.sv
module ptp_period_reg #(
  parameter int PER_NS_W   = 8,
  parameter int FRAC_W     = 32,
  parameter int RST_PER_NS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [PER_NS_W-1:0] ns_i,
  input  logic [FRAC_W-1:0]   frac_i,
  output logic [PER_NS_W-1:0] ns_o,
  output logic [FRAC_W-1:0]   frac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_o   <= PER_NS_W'(RST_PER_NS);
      frac_o <= '0;
    end else if (we_i) begin
      ns_o   <= ns_i;
      frac_o <= frac_i;
    end
  end
endmodule

// File: rtl/ptp_steer_mux.sv
module ptp_steer_mux
  import ptp_time_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int FRAC_W     = 32,
  parameter int OUT_FRAC_W = 8,
  parameter int ADJ_W      = 32
) (
  input  logic                  load_i,
  input  logic                  adjust_i,
  input  logic [SEC_W-1:0]      cur_sec_i,
  input  logic [NS_W-1:0]       cur_ns_i,
  input  logic [FRAC_W-1:0]     cur_frac_i,
  input  logic [SEC_W-1:0]      ld_sec_i,
  input  logic [NS_W-1:0]       ld_ns_i,
  input  logic [OUT_FRAC_W-1:0] ld_frac_i,
  input  logic [ADJ_W-1:0]      adj_ns_i,
  output logic [SEC_W-1:0]      base_sec_o,
  output logic [NS_W-1:0]       base_ns_o,
  output logic [FRAC_W-1:0]     base_frac_o,
  output logic [ADJ_W-1:0]      off_o
);
  localparam int PAD_W = FRAC_W - OUT_FRAC_W;

  steer_e sel;

  // load wins over adjust
  always_comb begin
    if (load_i)        sel = STEER_LOAD;
    else if (adjust_i) sel = STEER_ADJ;
    else               sel = STEER_NONE;
  end

  always_comb begin
    base_sec_o  = cur_sec_i;
    base_ns_o   = cur_ns_i;
    base_frac_o = cur_frac_i;
    off_o       = '0;
    unique case (sel)
      STEER_LOAD: begin
        base_sec_o  = ld_sec_i;
        base_ns_o   = ld_ns_i;
        base_frac_o = {ld_frac_i, {PAD_W{1'b0}}};
      end
      STEER_ADJ: off_o = adj_ns_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptp_ns_norm.sv
module ptp_ns_norm
  import ptp_time_pkg::*;
#(
  parameter int SEC_W    = 48,
  parameter int PER_NS_W = 8,
  parameter int FRAC_W   = 32,
  parameter int ADJ_W    = 32
) (
  input  logic [SEC_W-1:0]    sec_i,
  input  logic [NS_W-1:0]     ns_i,
  input  logic [FRAC_W-1:0]   frac_i,
  input  logic [PER_NS_W-1:0] per_ns_i,
  input  logic [FRAC_W-1:0]   per_frac_i,
  input  logic [ADJ_W-1:0]    off_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [NS_W-1:0]     ns_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic                carry_o
);
  localparam int SUM_W = ((ADJ_W > NS_W) ? ADJ_W : NS_W) + 3;
  localparam logic [SUM_W-1:0] LIM = SUM_W'(NS_PER_SEC);

  logic [FRAC_W:0]  frac_sum;
  logic [SUM_W-1:0] ns_sum;
  logic [SUM_W-1:0] ns_fix;

  assign frac_sum = {1'b0, frac_i} + {1'b0, per_frac_i};
  assign frac_o   = frac_sum[FRAC_W-1:0];

  // two's complement sum; MSB set means negative
  assign ns_sum = {{(SUM_W-NS_W){1'b0}}, ns_i}
                + {{(SUM_W-PER_NS_W){1'b0}}, per_ns_i}
                + {{(SUM_W-1){1'b0}}, frac_sum[FRAC_W]}
                + {{(SUM_W-ADJ_W){off_i[ADJ_W-1]}}, off_i};

  always_comb begin
    ns_fix  = ns_sum;
    sec_o   = sec_i;
    carry_o = 1'b0;
    if (ns_sum[SUM_W-1]) begin
      ns_fix = ns_sum + LIM;
      sec_o  = sec_i - SEC_W'(1);
    end else if (ns_sum >= LIM) begin
      ns_fix  = ns_sum - LIM;
      sec_o   = sec_i + SEC_W'(1);
      carry_o = 1'b1;
    end
  end

  assign ns_o = ns_fix[NS_W-1:0];
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_time_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int PER_NS_W   = 8,
  parameter int FRAC_W     = 32,
  parameter int OUT_FRAC_W = 8,
  parameter int ADJ_W      = 32,
  parameter int RST_PER_NS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [SEC_W-1:0]      ld_sec_i,
  input  logic [NS_W-1:0]       ld_ns_i,
  input  logic [OUT_FRAC_W-1:0] ld_frac_i,
  input  logic                  adjust_i,
  input  logic [ADJ_W-1:0]      adj_ns_i,
  input  logic                  period_we_i,
  input  logic [PER_NS_W-1:0]   per_ns_i,
  input  logic [FRAC_W-1:0]     per_frac_i,
  output logic [SEC_W-1:0]      sec_o,
  output logic [NS_W-1:0]       ns_o,
  output logic [OUT_FRAC_W-1:0] frac_o,
  output logic                  pps_tick_o
);
  logic [PER_NS_W-1:0] per_ns;
  logic [FRAC_W-1:0]   per_frac;
  logic [SEC_W-1:0]    sec_q, base_sec, nxt_sec;
  logic [NS_W-1:0]     ns_q, base_ns, nxt_ns;
  logic [FRAC_W-1:0]   frac_q, base_frac, nxt_frac;
  logic [ADJ_W-1:0]    off;
  logic                carry, tick_q;

  ptp_period_reg #(
    .PER_NS_W(PER_NS_W), .FRAC_W(FRAC_W), .RST_PER_NS(RST_PER_NS)
  ) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(period_we_i),
    .ns_i(per_ns_i), .frac_i(per_frac_i),
    .ns_o(per_ns), .frac_o(per_frac)
  );

  ptp_steer_mux #(
    .SEC_W(SEC_W), .FRAC_W(FRAC_W), .OUT_FRAC_W(OUT_FRAC_W), .ADJ_W(ADJ_W)
  ) u_steer (
    .load_i(load_i), .adjust_i(adjust_i),
    .cur_sec_i(sec_q), .cur_ns_i(ns_q), .cur_frac_i(frac_q),
    .ld_sec_i(ld_sec_i), .ld_ns_i(ld_ns_i), .ld_frac_i(ld_frac_i),
    .adj_ns_i(adj_ns_i),
    .base_sec_o(base_sec), .base_ns_o(base_ns), .base_frac_o(base_frac),
    .off_o(off)
  );

  ptp_ns_norm #(
    .SEC_W(SEC_W), .PER_NS_W(PER_NS_W), .FRAC_W(FRAC_W), .ADJ_W(ADJ_W)
  ) u_norm (
    .sec_i(base_sec), .ns_i(base_ns), .frac_i(base_frac),
    .per_ns_i(per_ns), .per_frac_i(per_frac), .off_i(off),
    .sec_o(nxt_sec), .ns_o(nxt_ns), .frac_o(nxt_frac), .carry_o(carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
      tick_q <= 1'b0;
    end else begin
      sec_q  <= nxt_sec;
      ns_q   <= nxt_ns;
      frac_q <= nxt_frac;
      tick_q <= carry;
    end
  end

  assign sec_o      = sec_q;
  assign ns_o       = ns_q;
  assign frac_o     = frac_q[FRAC_W-1 -: OUT_FRAC_W];
  assign pps_tick_o = tick_q;
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
  import ptp_time_pkg::*;
#(
  parameter int SEC_W    = 48,
  parameter int PER_NS_W = 8,
  parameter int FRAC_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                load_i,
  input logic                adjust_i,
  input logic                period_we_i,
  input logic [PER_NS_W-1:0] per_ns_i,
  input logic [FRAC_W-1:0]   per_frac_i,
  input logic [PER_NS_W-1:0] per_ns,
  input logic [FRAC_W-1:0]   per_frac,
  input logic [SEC_W-1:0]    sec_o,
  input logic [NS_W-1:0]     ns_o,
  input logic                pps_tick_o
);
  AST_NS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_o < NS_W'(NS_PER_SEC)); // R3

  AST_WRAP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adjust_i) |=> (!pps_tick_o || ns_o < $past(ns_o))); // R3

  AST_TICK_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (!pps_tick_o || sec_o == $past(sec_o) + SEC_W'(1))); // R4

  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adjust_i) |=> (pps_tick_o || sec_o == $past(sec_o))); // R2

  AST_PERIOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_we_i |=> ($stable(per_ns) && $stable(per_frac))); // R8

  AST_PERIOD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_we_i |=> (per_ns == $past(per_ns_i) && per_frac == $past(per_frac_i))); // R8
endmodule

bind ptp_time_counter ptp_time_counter_chk #(
  .SEC_W(SEC_W), .PER_NS_W(PER_NS_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .adjust_i(adjust_i),
  .period_we_i(period_we_i), .per_ns_i(per_ns_i), .per_frac_i(per_frac_i),
  .per_ns(per_ns), .per_frac(per_frac),
  .sec_o(sec_o), .ns_o(ns_o), .pps_tick_o(pps_tick_o)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam longint NSEC     = 1000000000;
  localparam longint SEC_MASK = (64'd1 << 48) - 1;
  localparam longint F_MASK   = 64'hFFFF_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [47:0] ld_sec_i = '0;
  logic [29:0] ld_ns_i = '0;
  logic [7:0]  ld_frac_i = '0;
  logic        adjust_i = 1'b0;
  logic [31:0] adj_ns_i = '0;
  logic        period_we_i = 1'b0;
  logic [7:0]  per_ns_i = '0;
  logic [31:0] per_frac_i = '0;
  logic [47:0] sec_o;
  logic [29:0] ns_o;
  logic [7:0]  frac_o;
  logic        pps_tick_o;

  ptp_time_counter u_dut (.*);

  always #10 clk_i = ~clk_i;

  int     n_checks = 0;
  int     n_errors = 0;
  bit     done = 1'b0;
  string  tag = "R1";

  longint m_sec = 0, m_ns = 0, m_frac = 0, m_pns = 8, m_pfrac = 0;
  bit     m_tick = 1'b0;

  // behavioural reference, advanced on the edge the DUT uses
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sec = 0; m_ns = 0; m_frac = 0; m_pns = 8; m_pfrac = 0; m_tick = 1'b0;
    end else begin
      longint bs, bn, bf, f, t;
      if (load_i) begin
        bs = longint'(ld_sec_i); bn = longint'(ld_ns_i);
        bf = longint'(ld_frac_i) << 24;
      end else begin
        bs = m_sec; bn = m_ns; bf = m_frac;
      end
      f = bf + m_pfrac;
      t = bn + m_pns + (f >> 32);
      if (adjust_i && !load_i) t = t + longint'(signed'(adj_ns_i));
      m_frac = f & F_MASK;
      m_tick = 1'b0;
      if (t >= NSEC) begin
        t = t - NSEC; bs = bs + 1; m_tick = 1'b1;
      end else if (t < 0) begin
        t = t + NSEC; bs = bs - 1;
      end
      m_sec = bs & SEC_MASK;
      m_ns  = t;
      if (period_we_i) begin
        m_pns = longint'(per_ns_i); m_pfrac = longint'(per_frac_i);
      end
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      longint es, en, ef;
      es = m_sec; en = m_ns; ef = m_frac >> 24;
      n_checks++;
      if (longint'(sec_o) != es || longint'(ns_o) != en ||
          longint'(frac_o) != ef || pps_tick_o != m_tick) begin
        n_errors++;
        $display("FAIL %s: got sec=%0d ns=%0d frac=%0h tick=%0b, expected sec=%0d ns=%0d frac=%0h tick=%0b",
                 tag, sec_o, ns_o, frac_o, pps_tick_o, es, en, ef, m_tick);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_load(input longint s, input longint ns, input int fr);
    @(negedge clk_i);
    load_i = 1'b1; ld_sec_i = s[47:0]; ld_ns_i = ns[29:0]; ld_frac_i = fr[7:0];
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_adj(input int off);
    @(negedge clk_i);
    adjust_i = 1'b1; adj_ns_i = off;
    @(negedge clk_i);
    adjust_i = 1'b0;
  endtask

  task automatic do_per(input int pn, input longint pf);
    @(negedge clk_i);
    period_we_i = 1'b1; per_ns_i = pn[7:0]; per_frac_i = pf[31:0];
    @(negedge clk_i);
    period_we_i = 1'b0;
  endtask

  initial begin
    tag = "R1 reset";
    idle(3);
    @(negedge clk_i) rst_ni = 1'b1;
    tag = "R1 first edges";  idle(3);
    tag = "R2 nominal";      idle(5);
    tag = "R8 period 8.5";   do_per(8, 64'h8000_0000); idle(6);
    tag = "R2 fraction 7.999"; do_per(7, 64'hFFFF_FF00); idle(20);
    tag = "R2 fraction 8.0039"; do_per(8, 64'h0100_0000); idle(10);
    do_per(8, 0);
    tag = "R5 load";         do_load(5, 999999950, 8'h40); idle(2);
    tag = "R3 R4 rollover";  idle(10);
    tag = "R6 adjust +";     do_adj(1000); idle(2);
    tag = "R6 adjust -";     do_adj(-500); idle(2);
    tag = "R7 borrow";       do_load(3, 100, 0); do_adj(-1000); idle(3);
    tag = "R7 R3 borrow at zero"; do_load(0, 10, 0); do_adj(-100); idle(3);
    tag = "R3 seconds wrap"; do_load(64'hFFFF_FFFF_FFFF, 999999990, 8'h80); idle(4);
    tag = "R4 adjust across second"; do_load(9, 999999000, 0); do_adj(2000); idle(3);
    tag = "R9 load+adjust";
    @(negedge clk_i);
    load_i = 1'b1; adjust_i = 1'b1; ld_sec_i = 48'd42; ld_ns_i = 30'd500; ld_frac_i = 8'h10;
    adj_ns_i = 32'd123456;
    @(negedge clk_i);
    load_i = 1'b0; adjust_i = 1'b0;
    idle(3);
    tag = "R10 period+adjust";
    @(negedge clk_i);
    adjust_i = 1'b1; adj_ns_i = -32'sd77; period_we_i = 1'b1; per_ns_i = 8'd9; per_frac_i = 32'h4000_0000;
    @(negedge clk_i);
    adjust_i = 1'b0; period_we_i = 1'b0;
    idle(4);
    tag = "R10 period+load";
    @(negedge clk_i);
    load_i = 1'b1; ld_sec_i = 48'd7; ld_ns_i = 30'd999999995; ld_frac_i = 8'hF0;
    period_we_i = 1'b1; per_ns_i = 8'd8; per_frac_i = 32'd0;
    @(negedge clk_i);
    load_i = 1'b0; period_we_i = 1'b0;
    idle(6);
    tag = "R1 reset again";
    @(negedge clk_i) rst_ni = 1'b0;
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule